// File: doc/BRIEF.md
# Bus-Multiplexed Bidirectional GPIO Port

This block is an eight-bit bidirectional I/O port. It has an output latch and a per-pin direction register, and both are reached through a simple CPU register interface. The register interface has separate write and read strobes for the latch and for the direction register. A bank-select value qualifies every access: only one bank value reaches the port's registers.

A two-bit operating-mode input can hand the pins to an external multiplexed address/data bus. In that case the pins carry the upper byte of that bus, and the GPIO registers no longer reach the pads. On the pad side, the tristate buffer is modelled as three separate vectors: pin output value, pin output enable and pin input value. Pin inputs pass through a multi-stage synchronizer before anything else in the block sees them. Register reads use the synchronized levels, and so does the input path of the system bus.

Top module: `muxbus_gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register holds all ones and the output latch holds all zeros. In GPIO modes, no pad output enable is active after reset.
- R2: Modes 2'b00 and 2'b01 are GPIO modes. In a GPIO mode, pad_oe[i] is 1 exactly when direction bit i is 0. A direction bit of 1 makes its pin an input.
- R3: A data-register read returns the pin levels after two clock edges of synchronization, not the latch contents. With the default of two stages, the level present at pad_in before edge k is returned from edge k+1 onward.
- R4: A latch write changes only the latch. On a pin that is an input, the written value is kept and appears on pad_out. It drives the pad only once that pin's direction bit becomes 0.
- R5: Modes 2'b10 and 2'b11 are bus modes. In a bus mode, pad_out equals sys_ado and every bit of pad_oe equals sys_drive. The latch and direction contents have no effect on the pads.
- R6: In a bus mode with sys_drive low, sys_din captures the synchronized pin levels on every clock edge. In all other cases, sys_din holds its value. sys_din resets to zero.
- R7: Writes take effect and reads return data only while bank_sel equals 1. For any other bank value, writes are ignored and reg_rdata is zero.
- R8: A direction-register read returns the stored direction value. When both read strobes are high, the data read takes priority. When no read strobe is high, reg_rdata is zero.
- R9: Writing 0x00 to the latch and then 0xCF to the direction register leaves bits 5:4 as outputs that drive 0 and all other pins as inputs (pad_oe = 0x30).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode; bit 1 set selects bus mode |
| bank_sel | input | 4 | Register bank select; the port answers only bank 1 |
| wr_lat | input | 1 | Write strobe for the output latch |
| wr_dir | input | 1 | Write strobe for the direction register |
| rd_dat | input | 1 | Read strobe for the synchronized pin levels |
| rd_dir | input | 1 | Read strobe for the direction register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, zero when no valid read is active |
| sys_ado | input | 8 | System-bus high address/data byte to drive |
| sys_drive | input | 1 | System-bus drive enable |
| sys_din | output | 8 | Captured pin levels for the system bus |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 drives |
| pad_in | input | 8 | Pad input levels |

## Verification
The hardest situation to reach is a latch value written while its pins are inputs, or while the port is in a bus mode. That value must stay hidden until the direction or the mode changes, and then it must appear on the pads. The stimulus writes the latch first, changes direction bits and the mode in later cycles, and then leaves the port in GPIO mode. A cycle-by-cycle reference model tracks the latch, the direction register and the pin history through the synchronizer delay. It compares every output on every clock, including sys_din while sys_drive is toggled in the bus modes.

// File: rtl/muxgpio_pkg.sv
package muxgpio_pkg;
   typedef enum logic [1:0] {
      OPM_MCU     = 2'b00,
      OPM_MCU_SEC = 2'b01,
      OPM_EXT     = 2'b10,
      OPM_MPU     = 2'b11
   } opmode_e;

   function automatic logic opm_is_bus(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int         W           = 8,
   parameter int         BANK_W      = 4,
   parameter int         ACTIVE_BANK = 1,
   parameter logic [W-1:0] DIR_RST   = '1,
   parameter logic [W-1:0] LAT_RST   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              wr_lat,
   input  logic              wr_dir,
   input  logic              rd_dat,
   input  logic              rd_dir,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      pins_sync,
   output logic [W-1:0]      lat_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      rdata
);
   localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(ACTIVE_BANK);

   if (ACTIVE_BANK >= (1 << BANK_W)) begin : g_bad_bank
      $error("gpio_regs: ACTIVE_BANK does not fit in BANK_W");
   end

   logic bank_ok;
   assign bank_ok = (bank_sel == BANK_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= LAT_RST;
      end else if (bank_ok && wr_lat) begin
         lat_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST;
      end else if (bank_ok && wr_dir) begin
         dir_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (bank_ok) begin
         if (rd_dat)      rdata = pins_sync;
         else if (rd_dir) rdata = dir_q;
      end
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_ok && wr_lat) |=> $stable(lat_q)); // R4
   AST_DIR_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_ok |=> $stable(dir_q)); // R7
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_mode,
   input  logic [W-1:0] lat_q,
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] sys_ado,
   input  logic         sys_drive,
   input  logic [W-1:0] pins_sync,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] sys_din
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         if (bus_mode) begin
            pad_out[i] = sys_ado[i];
            pad_oe[i]  = sys_drive;
         end else begin
            pad_out[i] = lat_q[i];
            pad_oe[i]  = ~dir_q[i];
         end
      end
   end

   logic capture;
   assign capture = bus_mode && !sys_drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sys_din <= '0;
      else if (capture) sys_din <= pins_sync;
   end

   AST_SYSIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(sys_din)); // R6
endmodule

// File: rtl/muxbus_gpio_port.sv
module muxbus_gpio_port #(
   parameter int W           = 8,
   parameter int BANK_W      = 4,
   parameter int ACTIVE_BANK = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_mode,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              wr_lat,
   input  logic              wr_dir,
   input  logic              rd_dat,
   input  logic              rd_dir,
   input  logic [W-1:0]      reg_wdata,
   output logic [W-1:0]      reg_rdata,
   input  logic [W-1:0]      sys_ado,
   input  logic              sys_drive,
   output logic [W-1:0]      sys_din,
   output logic [W-1:0]      pad_out,
   output logic [W-1:0]      pad_oe,
   input  logic [W-1:0]      pad_in
);
   import muxgpio_pkg::*;

   logic         bus_mode;
   logic [W-1:0] pins_sync;
   logic [W-1:0] lat_q;
   logic [W-1:0] dir_q;

   assign bus_mode = opm_is_bus(op_mode);

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pins_sync)
   );

   gpio_regs #(.W(W), .BANK_W(BANK_W), .ACTIVE_BANK(ACTIVE_BANK)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_sel  (bank_sel),
      .wr_lat    (wr_lat),
      .wr_dir    (wr_dir),
      .rd_dat    (rd_dat),
      .rd_dir    (rd_dir),
      .wdata     (reg_wdata),
      .pins_sync (pins_sync),
      .lat_q     (lat_q),
      .dir_q     (dir_q),
      .rdata     (reg_rdata)
   );

   gpio_padmux #(.W(W)) u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_mode  (bus_mode),
      .lat_q     (lat_q),
      .dir_q     (dir_q),
      .sys_ado   (sys_ado),
      .sys_drive (sys_drive),
      .pins_sync (pins_sync),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .sys_din   (sys_din)
   );

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_RDATA_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel != BANK_W'(ACTIVE_BANK)) |-> (reg_rdata == '0)); // R7

   if (SYNC_STAGES == 2) begin : g_lat_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 2'd2 && rd_dat && bank_sel == BANK_W'(ACTIVE_BANK))
            |-> (reg_rdata == $past(pad_in, 2))); // R3
   end
endmodule

// File: tb/tb_muxbus_gpio_port.sv
module tb_muxbus_gpio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_mode = 2'b00;
   logic [3:0] bank_sel = 4'd1;
   logic       wr_lat = 0, wr_dir = 0, rd_dat = 0, rd_dir = 0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] sys_ado = '0;
   logic       sys_drive = 0;
   logic [7:0] sys_din, pad_out, pad_oe;
   logic [7:0] pad_in = '0;

   int total = 0;
   int bad = 0;

   // reference model state
   logic [7:0] m_lat, m_dir, m_sys;
   logic [7:0] hist [$];

   always #2 clk = ~clk;

   muxbus_gpio_port dut (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .bank_sel(bank_sel),
      .wr_lat(wr_lat), .wr_dir(wr_dir), .rd_dat(rd_dat), .rd_dir(rd_dir),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_ado(sys_ado),
      .sys_drive(sys_drive), .sys_din(sys_din), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_in(pad_in)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_lat = 8'h00;
      m_dir = 8'hFF;
      m_sys = 8'h00;
      hist = '{8'h00, 8'h00};
   endtask

   task automatic compare();
      logic bus;
      logic ok;
      logic [7:0] e_rd;
      bus = op_mode[1];
      ok  = (bank_sel == 4'd1);
      e_rd = 8'h00;
      if (ok && rd_dat)      e_rd = hist[1];
      else if (ok && rd_dir) e_rd = m_dir;
      if (bus) begin
         chk("R5 pad_oe", pad_oe, {8{sys_drive}});
         chk("R5 pad_out", pad_out, sys_ado);
      end else begin
         chk("R2 pad_oe", pad_oe, ~m_dir);
         chk("R4 pad_out", pad_out, m_lat);
      end
      if (rd_dat) chk("R3 rdata", reg_rdata, e_rd);
      else        chk("R8 rdata", reg_rdata, e_rd);
      chk("R6 sys_din", sys_din, m_sys);
   endtask

   task automatic cycle(input int n = 1);
      for (int k = 0; k < n; k++) begin
         #1;
         if (rst_n) compare();
         @(posedge clk);
         if (!rst_n) model_reset();
         else begin
            if (bank_sel == 4'd1 && wr_lat) m_lat = reg_wdata;
            if (bank_sel == 4'd1 && wr_dir) m_dir = reg_wdata;
            if (op_mode[1] && !sys_drive) m_sys = hist[1];
            hist[1] = hist[0];
            hist[0] = pad_in;
         end
         @(negedge clk);
      end
   endtask

   task automatic idle();
      wr_lat = 0; wr_dir = 0; rd_dat = 0; rd_dir = 0;
   endtask

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      cycle(3);
      rst_n = 1'b1;
      #1;
      chk("R1 reset oe", pad_oe, 8'h00);
      chk("R1 reset out", pad_out, 8'h00);
      rd_dir = 1;
      #1;
      chk("R1 reset dir", reg_rdata, 8'hFF);
      cycle(1);
      idle();

      // latch write while pins are inputs: value parked
      wr_lat = 1; reg_wdata = 8'hA5; cycle(1); idle();
      chk("R4 parked oe", pad_oe, 8'h00);
      wr_dir = 1; reg_wdata = 8'h0F; cycle(1); idle();
      chk("R4 switched oe", pad_oe, 8'hF0);
      chk("R4 switched out", pad_out, 8'hA5);
      cycle(1);

      // pin reads through the synchronizer
      rd_dat = 1;
      for (int k = 0; k < 20; k++) begin
         pad_in = 8'($urandom);
         cycle(1);
      end
      pad_in = 8'h3C; cycle(3);
      #1 chk("R3 pins not latch", reg_rdata, 8'h3C);
      rd_dir = 1; #1 chk("R8 data priority", reg_rdata, 8'h3C);
      cycle(1); rd_dat = 0; cycle(1); idle();

      // wrong bank: write ignored, read zero
      bank_sel = 4'd0; wr_dir = 1; reg_wdata = 8'h00; cycle(1);
      wr_dir = 0; rd_dir = 1; #1 chk("R7 wrong bank read", reg_rdata, 8'h00);
      cycle(1);
      bank_sel = 4'd5; wr_lat = 1; reg_wdata = 8'hFF; cycle(1); idle();
      bank_sel = 4'd1; rd_dir = 1; #1 chk("R7 dir unchanged", reg_rdata, 8'h0F);
      chk("R7 latch unchanged", pad_out, 8'hA5);
      cycle(1); idle();

      // initialisation sequence, in mode 01
      op_mode = 2'b01;
      wr_lat = 1; reg_wdata = 8'h00; cycle(1); idle();
      wr_dir = 1; reg_wdata = 8'hCF; cycle(1); idle();
      #1 chk("R9 init oe", pad_oe, 8'h30);
      chk("R9 init out", pad_out & pad_oe, 8'h00);
      cycle(1);

      // bus modes
      for (int m = 2; m < 4; m++) begin
         op_mode = 2'(m);
         wr_lat = 1; reg_wdata = 8'h5A;
         for (int k = 0; k < 40; k++) begin
            sys_ado = 8'($urandom);
            sys_drive = (k % 5) < 2;
            pad_in = 8'($urandom);
            rd_dat = k[0];
            cycle(1);
            wr_lat = 0;
         end
         idle();
      end
      sys_drive = 1; sys_ado = 8'h81; #1;
      chk("R5 bus out", pad_out, 8'h81);
      chk("R5 bus oe", pad_oe, 8'hFF);
      cycle(1);

      // back to GPIO: latch written in bus mode now shows
      op_mode = 2'b00; sys_drive = 0;
      wr_dir = 1; reg_wdata = 8'h00; cycle(1); idle();
      #1 chk("R4 latch after bus", pad_out, 8'h5A);
      chk("R2 all out", pad_oe, 8'hFF);
      cycle(1);

      // random mix
      for (int k = 0; k < 400; k++) begin
         op_mode   = 2'($urandom);
         bank_sel  = ($urandom % 3 == 0) ? 4'($urandom) : 4'd1;
         wr_lat    = 1'($urandom);
         wr_dir    = 1'($urandom);
         rd_dat    = 1'($urandom);
         rd_dir    = 1'($urandom);
         reg_wdata = 8'($urandom);
         sys_ado   = 8'($urandom);
         sys_drive = 1'($urandom);
         pad_in    = 8'($urandom);
         cycle(1);
      end
      idle();
      cycle(2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule